// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is a single 32-bit timer channel with a small word-addressed register port. Software loads a reload value and a start count, selects a clock divider and enables the interrupt. It then raises the channel enable input. While the channel runs, the counter steps down once per divided clock tick. When a tick arrives with the counter at zero, the counter takes the reload value instead of wrapping, and a sticky underflow flag is set. The interrupt line is the flag gated by the interrupt enable bit.

A two-state machine follows the enable input. In `CH_STOPPED` the divider is held at zero and the counter does not move. On the `go` transition (enable seen high) the machine enters `CH_RUNNING`, where the divider runs freely and emits one-cycle tick pulses. On the `halt` transition (enable seen low) it returns to `CH_STOPPED`. The two fields for clock-edge selection and capture enable are kept only as storage and do not change how the counter counts.

Top module: `tmr_channel`

## Requirements
- R1: After reset the reload register and the counter both read 0xFFFFFFFF, the control register reads 0, and `irq` is 0.
- R2: `bus_addr[3:2]` selects the register: 0 is reload, 1 is counter, 2 is control and 3 is capture. Address bits above bit 3 must be zero for a hit. A miss reads 0 and writes nothing.
- R3: Control bits [2:0] hold a divider code. Codes 0, 1, 2, 3 and 4 make the counter step once every 4, 16, 64, 256 and 1024 clock cycles while running. Codes 5 to 7 give no ticks, so the counter holds.
- R4: A counter write loads the written value in the next cycle, and it takes priority over a tick in the same cycle. A control write clears the divider and suppresses the tick of that cycle.
- R5: A tick with the counter at 0 loads the reload value into the counter and sets the underflow flag. A tick with any other count decrements it by one.
- R6: A control write with bit 8 = 0 clears the underflow flag. With bit 8 = 1 it leaves the flag as it is. No write ever sets the flag.
- R7: `irq` equals the underflow flag AND control bit 5.
- R8: Control reads return the stored bits [7:0] and the current flag in bit 8. All other bits read 0, and reserved bits written as 1 are dropped.
- R9: The state machine enters `CH_RUNNING` one cycle after `chan_en` is seen high and returns to `CH_STOPPED` one cycle after it is seen low. While stopped, the counter changes only through a counter write, and the divider restarts from zero.
- R10: With `HAS_CAPTURE` = 1, the capture register holds the last value written to it and reads it back. Its reset value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel start (1) / stop (0) |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: flag AND enable |

## Verification
The bench drives the tick at zero for every divider code and checks three outcomes. A design that wraps to all ones instead of reloading would fail, and so would one that counts one cycle early or late. The bench also writes the control register with the flag bit at 1 while the flag is clear, to catch a write that wrongly sets the flag. It loads the counter and rewrites the control register in the middle of a divider period, so a design that lets a tick win over the counter load, or that keeps the old divider phase, would read a different count. It also selects codes 5 to 7 and stops the channel, to catch a counter that keeps moving.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        CH_STOPPED = 1'b0,
        CH_RUNNING = 1'b1
    } ch_state_e;

    localparam logic [1:0] SEL_RELOAD  = 2'd0;
    localparam logic [1:0] SEL_COUNTER = 2'd1;
    localparam logic [1:0] SEL_CONTROL = 2'd2;
    localparam logic [1:0] SEL_CAPTURE = 2'd3;

    localparam int IE_BIT   = 5;
    localparam int FLAG_BIT = 8;
    localparam int CTL_KEEP = 8;   // stored control bits [7:0]
    localparam int MAX_CODE = 4;   // highest divider code that ticks
endpackage

// File: rtl/tmr_run_fsm.sv
module tmr_run_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chan_en,
    output logic running
);
    ch_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOPPED: if (chan_en)  state_d = CH_RUNNING;  // go
            CH_RUNNING: if (!chan_en) state_d = CH_STOPPED;  // halt
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            CH_STOPPED: running = 1'b0;
            CH_RUNNING: running = 1'b1;
        endcase
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int PSC_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [PSC_W-1:0] pc_q;
    logic [PSC_W-1:0] last;
    logic             valid;

    always_comb begin
        valid = (int'(code) <= MAX_CODE);
        last  = '0;
        for (int k = 0; k <= MAX_CODE; k++) begin
            if (int'(code) == k) last = PSC_W'((1 << (2 * (k + 1))) - 1);
        end
    end

    assign tick = valid && !clear && (pc_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pc_q <= '0;
        else if (clear || !valid)   pc_q <= '0;
        else if (tick)              pc_q <= '0;
        else                        pc_q <= pc_q + 1'b1;
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int CODE_W      = 3,
    parameter int PSC_W       = 10,
    parameter bit HAS_CAPTURE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int SEL_LO = 2;

    logic [1:0]        sel;
    logic              hit;
    logic              reload_wr, cnt_wr, ctrl_wr, cap_wr;
    logic [DATA_W-1:0] reload_q, cnt_q, cap_q;
    logic [CTL_KEEP-1:0] ctrl_q;
    logic              flag_q;
    logic              running, tick;
    logic              unused_addr;

    assign unused_addr = ^bus_addr[SEL_LO-1:0];
    assign sel = bus_addr[SEL_LO+1:SEL_LO];
    assign hit = ((bus_addr >> (SEL_LO + 2)) == '0);

    assign reload_wr = bus_wr && hit && (sel == SEL_RELOAD);
    assign cnt_wr    = bus_wr && hit && (sel == SEL_COUNTER);
    assign ctrl_wr   = bus_wr && hit && (sel == SEL_CONTROL);
    assign cap_wr    = bus_wr && hit && (sel == SEL_CAPTURE);

    tmr_run_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_en (chan_en),
        .running (running)
    );

    tmr_prescaler #(.CODE_W(CODE_W), .PSC_W(PSC_W)) i_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!running || ctrl_wr),
        .code  (ctrl_q[CODE_W-1:0]),
        .tick  (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '1;
            cnt_q    <= '1;
            ctrl_q   <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (reload_wr) reload_q <= bus_wdata[DATA_W-1:0];
            if (cnt_wr) begin
                cnt_q <= bus_wdata[DATA_W-1:0];
            end else if (tick) begin
                if (cnt_q == '0) cnt_q <= reload_q;
                else             cnt_q <= cnt_q - 1'b1;
            end
            if (ctrl_wr) ctrl_q <= bus_wdata[CTL_KEEP-1:0];
            if (tick && cnt_q == '0 && !cnt_wr)      flag_q <= 1'b1;
            else if (ctrl_wr && !bus_wdata[FLAG_BIT]) flag_q <= 1'b0;
        end
    end

    generate
        if (HAS_CAPTURE) begin : g_cap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      cap_q <= '0;
                else if (cap_wr) cap_q <= bus_wdata[DATA_W-1:0];
            end
        end else begin : g_nocap
            assign cap_q = '0;
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            unique case (sel)
                SEL_RELOAD:  bus_rdata = 32'(reload_q);
                SEL_COUNTER: bus_rdata = 32'(cnt_q);
                SEL_CONTROL: bus_rdata = 32'({flag_q, ctrl_q});
                SEL_CAPTURE: bus_rdata = 32'(cap_q);
            endcase
        end
    end

    assign irq = flag_q && ctrl_q[IE_BIT];
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              flag_q,
    input logic              running,
    input logic              tick,
    input logic              cnt_wr,
    input logic              ctrl_wr,
    input logic [DATA_W-1:0] cnt_q,
    input logic [DATA_W-1:0] reload_q
);
    // R7
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);

    // R6
    no_write_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !$rose(flag_q));

    // R9
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_wr) |=> $stable(cnt_q));

    // R5
    reload_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == '0 && !cnt_wr) |=> (cnt_q == $past(reload_q)) && flag_q);

    // R3
    tick_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> running);
endmodule

bind tmr_channel tmr_channel_chk #(.DATA_W(DATA_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .flag_q   (flag_q),
    .running  (running),
    .tick     (tick),
    .cnt_wr   (cnt_wr),
    .ctrl_wr  (ctrl_wr),
    .cnt_q    (cnt_q),
    .reload_q (reload_q)
);

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    tmr_channel i_tmr_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // behavioural reference
    logic [31:0] m_reload, m_cnt, m_cap;
    logic [7:0]  m_ctrl;
    bit          m_flag, m_run;
    int          m_pc;

    function automatic int period(input int code);
        return (code <= 4) ? (4 ** (code + 1)) : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reload = 32'hFFFF_FFFF; m_cnt = 32'hFFFF_FFFF; m_cap = 0;
            m_ctrl = 0; m_flag = 0; m_run = 0; m_pc = 0;
        end else begin
            bit wr_c, wr_n, wr_r, wr_p, tk;
            int p;
            wr_r = bus_wr && bus_addr[3:2] == 2'd0;
            wr_n = bus_wr && bus_addr[3:2] == 2'd1;
            wr_c = bus_wr && bus_addr[3:2] == 2'd2;
            wr_p = bus_wr && bus_addr[3:2] == 2'd3;
            p = period(int'(m_ctrl[2:0]));
            tk = m_run && !wr_c && p != 0 && (m_pc == p - 1);
            if (!m_run || wr_c || p == 0 || tk) m_pc = 0;
            else m_pc = m_pc + 1;
            if (wr_n) m_cnt = bus_wdata;
            else if (tk) begin
                if (m_cnt == 0) begin m_cnt = m_reload; m_flag = 1; end
                else m_cnt = m_cnt - 1;
            end
            if (wr_c) begin
                if (!bus_wdata[8]) m_flag = 0;
                m_ctrl = bus_wdata[7:0];
            end
            if (wr_r) m_reload = bus_wdata;
            if (wr_p) m_cap = bus_wdata;
            m_run = chan_en;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] e;
            case (bus_addr[3:2])
                2'd0: e = m_reload;
                2'd1: e = m_cnt;
                2'd2: e = {23'd0, m_flag, m_ctrl};
                default: e = m_cap;
            endcase
            case (bus_addr[3:2])
                2'd0: check("R2 reload", bus_rdata, e);
                2'd1: check("R3 R4 R5 R9 counter", bus_rdata, e);
                2'd2: check("R6 R8 control", bus_rdata, e);
                default: check("R10 capture", bus_rdata, e);
            endcase
            check("R7 irq", {31'd0, irq}, {31'd0, m_flag && m_ctrl[5]});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(posedge clk); #2;
        bus_addr = a;
        @(negedge clk);
        check(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        logic [31:0] snap;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        rd_check("R1 reload reset", 4'h0, 32'hFFFF_FFFF);
        rd_check("R1 counter reset", 4'h4, 32'hFFFF_FFFF);
        rd_check("R1 control reset", 4'h8, 32'h0);
        check("R1 irq reset", {31'd0, irq}, 32'd0);

        // underflow with fastest divider, interrupt enabled
        wr(4'h0, 32'd5);
        wr(4'h4, 32'd2);
        wr(4'h8, 32'h20);
        @(posedge clk); #2 chan_en = 1'b1;
        bus_addr = 4'h4;
        idle(60);
        check("R5 R7 irq after underflow", {31'd0, irq}, 32'd1);

        // R6 keep with bit8=1, R7 gate by enable
        @(posedge clk); #2 chan_en = 1'b0;
        idle(3);
        wr(4'h8, 32'h120);
        rd_check("R6 flag kept", 4'h8, 32'h120);
        wr(4'h8, 32'h100);
        rd_check("R7 irq gated", 4'h8, 32'h100);
        check("R7 irq low when disabled", {31'd0, irq}, 32'd0);
        wr(4'h8, 32'h020);
        rd_check("R6 flag cleared", 4'h8, 32'h020);
        wr(4'h8, 32'h120);
        rd_check("R6 write cannot set", 4'h8, 32'h020);

        // R8 reserved bits dropped
        wr(4'h8, 32'hFFFF_FE27);
        rd_check("R8 reserved read zero", 4'h8, 32'h27);

        // R3 code 7 gives no ticks
        wr(4'h4, 32'd100);
        @(posedge clk); #2 chan_en = 1'b1;
        idle(200);
        rd_check("R3 code7 holds", 4'h4, 32'd100);

        // R9 stopped channel holds
        @(posedge clk); #2 chan_en = 1'b0;
        wr(4'h8, 32'h0);
        wr(4'h4, 32'd50);
        idle(100);
        rd_check("R9 stopped holds", 4'h4, 32'd50);

        // R3 R5 every divider code with small counts
        for (int c = 0; c <= 4; c++) begin
            @(posedge clk); #2 chan_en = 1'b0;
            wr(4'h0, 32'd2);
            wr(4'h4, 32'd1);
            wr(4'h8, 32'h20 | c);
            @(posedge clk); #2 chan_en = 1'b1;
            bus_addr = 4'h4;
            idle(4 * period(c) + 7);
        end

        // R4 mid-period counter load and control rewrite
        wr(4'h8, 32'h21);
        idle(9);
        wr(4'h4, 32'd7);
        idle(5);
        wr(4'h8, 32'h121);
        bus_addr = 4'h4;
        idle(40);
        snap = bus_rdata;
        @(posedge clk); #2 chan_en = 1'b0;
        idle(20);
        rd_check("R9 halted count stable", 4'h4, m_cnt);

        // R10 capture register
        wr(4'hC, 32'hA5A5_5A5A);
        rd_check("R10 capture readback", 4'hC, 32'hA5A5_5A5A);
        rd_check("R2 reload readback", 4'h0, 32'd2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule